// File: doc/BRIEF.md
# DMA Burst Trigger Scheduler

This block sits beside a video-capture DMA engine and decides, every clock, whether a burst write onto the system bus may begin. It also decides which pixel FIFO feeds that burst and how many DWORDs it carries. Its inputs are the kind of instruction being executed, the DWORDs still owed to that instruction, the fill counts of the luma FIFO and the two chroma FIFOs, a 2-bit trigger-level code, and the storage mode. In planar mode each FIFO is judged on its own. In packed mode the three counts are added and judged as one FIFO.

The engine normally waits until a FIFO holds enough data to make a bus access worthwhile. The threshold is overridden in three cases:
- when the instruction is about to end,
- during SKIP instructions,
- after the bus has disconnected the initiator in planar mode, until every FIFO has drained.

A parity error seen while instructions are being fetched halts all requests and raises an interrupt until software clears it.

Top module: `trig_sched`

## Requirements
- R1: The trigger-level code selects a threshold: 0 means 4 DWORDs, 1 means 8, 2 means 16 and 3 means 32. A WRITE (instr_kind 1) qualifies a FIFO whose fill is at or above that threshold.
- R2: A WRITE does not qualify a FIFO in these cases: its fill is below the threshold, the DWORDs left are not fewer than its fill, and no drain is in progress. A fill equal to the DWORDs left does not bypass the threshold.
- R3: A WRITE qualifies a non-empty FIFO regardless of threshold when the DWORDs left are fewer than the FIFO's fill.
- R4: A SKIP (instr_kind 2) qualifies any FIFO holding at least one DWORD, whatever the threshold.
- R5: In planar mode (planar=1), FIFOs share one threshold and priority is luma, then Cb, then Cr. burst_src codes are 0 for luma, 1 for Cb and 2 for Cr.
- R6: In packed mode (planar=0), the sum of the three fills is judged as one FIFO, and burst_src is 3.
- R7: A bus_disc pulse in planar mode, while any FIFO holds data, suspends the threshold for WRITEs until all three fills read zero. In packed mode bus_disc has no effect.
- R8: burst_len is the smallest of the chosen fill, the DWORDs left and MAX_BURST (16 by default).
- R9: par_err drops burst_req and raises irq from the next cycle. Both hold until an err_clear cycle without par_err, and par_err wins when both arrive together.
- R10: Outputs are registered, so each reflects the inputs of the previous cycle. Reset, instr_valid low, instr_kind 0 or 3, or zero DWORDs left all give burst_req=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is being executed |
| instr_kind | input | 2 | 0 none, 1 WRITE, 2 SKIP, 3 other |
| words_left | input | LEFT_W | DWORDs still owed to the current instruction |
| fill_y | input | FILL_W | Luma FIFO DWORD count |
| fill_cb | input | FILL_W | Cb FIFO DWORD count |
| fill_cr | input | FILL_W | Cr FIFO DWORD count |
| trig_code | input | 2 | Threshold code (4/8/16/32 DWORDs) |
| planar | input | 1 | 1 planar, 0 packed |
| bus_disc | input | 1 | Pulse: initiator was disconnected |
| par_err | input | 1 | Pulse: parity error on instruction fetch |
| err_clear | input | 1 | Software clear of the parity halt |
| burst_req | output | 1 | A burst may start |
| burst_src | output | 2 | Selected FIFO code |
| burst_len | output | LEN_W | DWORDs in the burst |
| irq | output | 1 | Parity-error interrupt |

## Verification
A parity error and a qualifying FIFO can fall in the same cycle. The bench holds luma above threshold so that a request is present, then pulses par_err. The request must vanish on the very next sample while irq rises. A second overlap, err_clear arriving together with par_err, is driven and judged by irq staying high. The clear is then given alone, and the request must not reappear until one cycle after irq falls.

// File: rtl/trig_sched_pkg.sv
package trig_sched_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SKIP  = 2'd2,
        OP_OTHER = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        SRC_Y      = 2'd0,
        SRC_CB     = 2'd1,
        SRC_CR     = 2'd2,
        SRC_PACKED = 2'd3
    } src_e;

    localparam int TRIG_W = 6;

    typedef struct packed {
        logic go;
        src_e src;
    } pick_t;

    function automatic logic [TRIG_W-1:0] trig_words(input logic [1:0] code);
        return 6'd4 << code;
    endfunction

endpackage

// File: rtl/trig_fifo_eval.sv
module trig_fifo_eval
    import trig_sched_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int LEFT_W    = 12,
    parameter int MAX_BURST = 16,
    parameter int LEN_W     = 5
) (
    input  logic                active,
    input  op_kind_e            kind,
    input  logic [CNT_W-1:0]    fill,
    input  logic [LEFT_W-1:0]   words_left,
    input  logic [TRIG_W-1:0]   trig,
    input  logic                force_trig,
    output logic                elig,
    output logic [LEN_W-1:0]    len
);
    localparam int BASE_W = (CNT_W > LEFT_W) ? CNT_W : LEFT_W;
    localparam int CMP_W  = ((BASE_W > TRIG_W) ? BASE_W : TRIG_W) + 1;

    logic [CMP_W-1:0] f, l, t, mx, m;
    logic             gate;

    always_comb begin
        f  = CMP_W'(fill);
        l  = CMP_W'(words_left);
        t  = CMP_W'(trig);
        mx = CMP_W'(MAX_BURST);
        unique case (kind)
            OP_WRITE: gate = (f >= t) || (l < f) || force_trig;
            OP_SKIP:  gate = 1'b1;
            default:  gate = 1'b0;
        endcase
        elig = active && (f != '0) && (l != '0) && gate;
        m = (f < l) ? f : l;
        if (m > mx) m = mx;
        len = LEN_W'(m);
    end

endmodule

// File: rtl/trig_ctrl_state.sv
module trig_ctrl_state (
    input  logic clk,
    input  logic rst,
    input  logic planar,
    input  logic bus_disc,
    input  logic any_queued,
    input  logic par_err,
    input  logic err_clear,
    output logic flush,
    output logic halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flush  <= 1'b0;
            halted <= 1'b0;
        end else begin
            if (bus_disc && planar && any_queued) flush <= 1'b1;
            else if (!any_queued)                 flush <= 1'b0;

            if (par_err)        halted <= 1'b1;
            else if (err_clear) halted <= 1'b0;
        end
    end

    AST_FLUSH_ENDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (flush && !any_queued) |=> !flush); // R7
    AST_PACKED_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (!planar && !flush) |=> !flush); // R7
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (halted && !err_clear) |=> halted); // R9

endmodule

// File: rtl/trig_sched.sv
module trig_sched
    import trig_sched_pkg::*;
#(
    parameter int FILL_W    = 7,
    parameter int LEFT_W    = 12,
    parameter int MAX_BURST = 16,
    localparam int LEN_W    = $clog2(MAX_BURST + 1),
    localparam int SUM_W    = FILL_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [1:0]        instr_kind,
    input  logic [LEFT_W-1:0] words_left,
    input  logic [FILL_W-1:0] fill_y,
    input  logic [FILL_W-1:0] fill_cb,
    input  logic [FILL_W-1:0] fill_cr,
    input  logic [1:0]        trig_code,
    input  logic              planar,
    input  logic              bus_disc,
    input  logic              par_err,
    input  logic              err_clear,
    output logic              burst_req,
    output logic [1:0]        burst_src,
    output logic [LEN_W-1:0]  burst_len,
    output logic              irq
);
    localparam int NFIFO = 3;

    op_kind_e            kind;
    logic [TRIG_W-1:0]   trig;
    logic [FILL_W-1:0]   fills [NFIFO];
    logic [NFIFO-1:0]    el;
    logic [LEN_W-1:0]    ln [NFIFO];
    logic [SUM_W-1:0]    sum_fill;
    logic                pk_el;
    logic [LEN_W-1:0]    pk_len;
    logic                flush, halted, any_queued;
    pick_t               pick;
    logic [LEN_W-1:0]    pick_len;

    assign kind       = op_kind_e'(instr_kind);
    assign trig       = trig_words(trig_code);
    assign fills[0]   = fill_y;
    assign fills[1]   = fill_cb;
    assign fills[2]   = fill_cr;
    assign sum_fill   = {2'b00, fill_y} + {2'b00, fill_cb} + {2'b00, fill_cr};
    assign any_queued = (sum_fill != '0);

    trig_ctrl_state u_state (
        .clk        (clk),
        .rst        (rst),
        .planar     (planar),
        .bus_disc   (bus_disc),
        .any_queued (any_queued),
        .par_err    (par_err),
        .err_clear  (err_clear),
        .flush      (flush),
        .halted     (halted)
    );

    for (genvar g = 0; g < NFIFO; g++) begin : g_plane
        trig_fifo_eval #(
            .CNT_W(FILL_W), .LEFT_W(LEFT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
        ) u_eval (
            .active     (instr_valid),
            .kind       (kind),
            .fill       (fills[g]),
            .words_left (words_left),
            .trig       (trig),
            .force_trig (flush),
            .elig       (el[g]),
            .len        (ln[g])
        );
    end

    trig_fifo_eval #(
        .CNT_W(SUM_W), .LEFT_W(LEFT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
    ) u_packed (
        .active     (instr_valid),
        .kind       (kind),
        .fill       (sum_fill),
        .words_left (words_left),
        .trig       (trig),
        .force_trig (1'b0),
        .elig       (pk_el),
        .len        (pk_len)
    );

    always_comb begin
        pick     = '{go: 1'b0, src: SRC_Y};
        pick_len = '0;
        if (planar) begin
            if (el[0]) begin
                pick = '{go: 1'b1, src: SRC_Y};  pick_len = ln[0];
            end else if (el[1]) begin
                pick = '{go: 1'b1, src: SRC_CB}; pick_len = ln[1];
            end else if (el[2]) begin
                pick = '{go: 1'b1, src: SRC_CR}; pick_len = ln[2];
            end
        end else if (pk_el) begin
            pick = '{go: 1'b1, src: SRC_PACKED}; pick_len = pk_len;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_req <= 1'b0;
            burst_src <= SRC_Y;
            burst_len <= '0;
        end else begin
            burst_req <= pick.go && !halted && !par_err;
            burst_src <= pick.src;
            burst_len <= pick_len;
        end
    end

    assign irq = halted;

    AST_NO_REQ_WHILE_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq |-> !burst_req); // R9
    AST_PARITY_STOP: assert property (@(posedge clk) disable iff (rst)
        par_err |=> (!burst_req && irq)); // R9
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (err_clear && !par_err) |=> !irq); // R9
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> (burst_len != '0 && burst_len <= LEN_W'(MAX_BURST))); // R8
    AST_NO_INSTR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> !burst_req); // R10

endmodule

// File: tb/trig_sched_bench.sv
`timescale 1ns/100ps
module trig_sched_bench;
    localparam int FILL_W = 7;
    localparam int LEFT_W = 12;
    localparam int MAXB   = 16;
    localparam int LEN_W  = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic instr_valid = 1'b0;
    logic [1:0] instr_kind = 2'd0;
    logic [LEFT_W-1:0] words_left = '0;
    logic [FILL_W-1:0] fill_y = '0, fill_cb = '0, fill_cr = '0;
    logic [1:0] trig_code = 2'd0;
    logic planar = 1'b1, bus_disc = 1'b0, par_err = 1'b0, err_clear = 1'b0;
    logic burst_req, irq;
    logic [1:0] burst_src;
    logic [LEN_W-1:0] burst_len;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trig_sched #(.FILL_W(FILL_W), .LEFT_W(LEFT_W), .MAX_BURST(MAXB)) u_trig_sched (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_kind(instr_kind),
        .words_left(words_left), .fill_y(fill_y), .fill_cb(fill_cb), .fill_cr(fill_cr),
        .trig_code(trig_code), .planar(planar), .bus_disc(bus_disc), .par_err(par_err),
        .err_clear(err_clear), .burst_req(burst_req), .burst_src(burst_src),
        .burst_len(burst_len), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_burst(input string tag, input int req, input int src, input int len);
        chk({tag, " req"}, int'(burst_req), req);
        if (req != 0) begin
            chk({tag, " src"}, int'(burst_src), src);
            chk({tag, " len"}, int'(burst_len), len);
        end
    endtask

    task automatic set_fills(input int y, input int cb, input int cr);
        fill_y = FILL_W'(y); fill_cb = FILL_W'(cb); fill_cr = FILL_W'(cr);
    endtask

    task automatic t_reset();
        instr_valid = 1'b1; instr_kind = 2'd1; words_left = 12'd100;
        set_fills(40, 40, 40);
        step(); step();
        chk("R10 reset req", int'(burst_req), 0);
        chk("R10 reset irq", int'(irq), 0);
        rst = 1'b0;
        set_fills(0, 0, 0);
        step();
        chk("R10 empty after reset", int'(burst_req), 0);
    endtask

    task automatic t_threshold();
        planar = 1'b1; instr_kind = 2'd1; words_left = 12'd100; trig_code = 2'd1;
        set_fills(7, 0, 0); step();
        chk_burst("R2 below 8", 0, 0, 0);
        set_fills(8, 0, 0); step();
        chk_burst("R1 at 8", 1, 0, 8);
        trig_code = 2'd0; set_fills(4, 0, 0); step();
        chk_burst("R1 at 4", 1, 0, 4);
        trig_code = 2'd2; set_fills(15, 0, 0); step();
        chk_burst("R2 below 16", 0, 0, 0);
        trig_code = 2'd3; set_fills(31, 0, 0); step();
        chk_burst("R2 below 32", 0, 0, 0);
        set_fills(32, 0, 0); step();
        chk_burst("R1 R8 at 32 capped", 1, 0, MAXB);
    endtask

    task automatic t_bypass();
        planar = 1'b1; instr_kind = 2'd1; trig_code = 2'd3;
        set_fills(10, 0, 0); words_left = 12'd9; step();
        chk_burst("R3 left<fill", 1, 0, 9);
        words_left = 12'd10; step();
        chk_burst("R2 left==fill", 0, 0, 0);
        set_fills(0, 0, 3); words_left = 12'd2; step();
        chk_burst("R3 R8 Cr ending", 1, 2, 2);
    endtask

    task automatic t_skip();
        planar = 1'b1; instr_kind = 2'd2; trig_code = 2'd3; words_left = 12'd50;
        set_fills(0, 0, 1); step();
        chk_burst("R4 skip one dword", 1, 2, 1);
        set_fills(0, 0, 0); step();
        chk_burst("R4 skip empty", 0, 0, 0);
    endtask

    task automatic t_priority();
        planar = 1'b1; instr_kind = 2'd1; trig_code = 2'd0; words_left = 12'd100;
        set_fills(5, 6, 7); step();
        chk_burst("R5 luma first", 1, 0, 5);
        set_fills(0, 6, 7); step();
        chk_burst("R5 Cb over Cr", 1, 1, 6);
        set_fills(3, 2, 7); step();
        chk_burst("R5 only Cr qualifies", 1, 2, 7);
    endtask

    task automatic t_packed();
        planar = 1'b0; instr_kind = 2'd1; trig_code = 2'd2; words_left = 12'd100;
        set_fills(6, 5, 5); step();
        chk_burst("R6 sum at 16", 1, 3, 16);
        set_fills(6, 5, 4); step();
        chk_burst("R6 sum 15", 0, 0, 0);
        words_left = 12'd12; set_fills(6, 5, 4); step();
        chk_burst("R6 R8 packed ending", 1, 3, 12);
    endtask

    task automatic t_disconnect();
        planar = 1'b1; instr_kind = 2'd1; trig_code = 2'd3; words_left = 12'd100;
        set_fills(3, 2, 0); step();
        chk_burst("R7 before disc", 0, 0, 0);
        bus_disc = 1'b1; step();
        bus_disc = 1'b0;
        chk_burst("R7 disc latency", 0, 0, 0);
        step();
        chk_burst("R7 drain luma", 1, 0, 3);
        set_fills(0, 2, 0); step();
        chk_burst("R7 drain Cb", 1, 1, 2);
        set_fills(0, 0, 0); step();
        chk_burst("R7 drained", 0, 0, 0);
        set_fills(3, 0, 0); step();
        chk_burst("R7 threshold back", 0, 0, 0);
        planar = 1'b0; set_fills(3, 2, 0);
        bus_disc = 1'b1; step();
        bus_disc = 1'b0; step();
        chk_burst("R7 packed disc ignored", 0, 0, 0);
        planar = 1'b1; step(); step();
        chk_burst("R7 no drain left from packed", 0, 0, 0);
    endtask

    task automatic t_parity();
        planar = 1'b1; instr_kind = 2'd1; trig_code = 2'd0; words_left = 12'd100;
        set_fills(8, 0, 0); step();
        chk_burst("R9 pre", 1, 0, 8);
        par_err = 1'b1; step();
        par_err = 1'b0;
        chk("R9 stop req", int'(burst_req), 0);
        chk("R9 irq up", int'(irq), 1);
        step();
        chk("R9 held req", int'(burst_req), 0);
        chk("R9 held irq", int'(irq), 1);
        par_err = 1'b1; err_clear = 1'b1; step();
        par_err = 1'b0; err_clear = 1'b0;
        chk("R9 parity beats clear", int'(irq), 1);
        err_clear = 1'b1; step();
        err_clear = 1'b0;
        chk("R9 cleared irq", int'(irq), 0);
        chk("R9 req one cycle late", int'(burst_req), 0);
        step();
        chk_burst("R9 resumed", 1, 0, 8);
    endtask

    task automatic t_gating();
        planar = 1'b1; trig_code = 2'd0; words_left = 12'd100; set_fills(20, 0, 0);
        instr_kind = 2'd1; instr_valid = 1'b0; step();
        chk_burst("R10 no instr", 0, 0, 0);
        instr_valid = 1'b1; instr_kind = 2'd3; step();
        chk_burst("R10 other kind", 0, 0, 0);
        instr_kind = 2'd0; step();
        chk_burst("R10 kind none", 0, 0, 0);
        instr_kind = 2'd1; words_left = 12'd0; step();
        chk_burst("R10 zero left", 0, 0, 0);
        words_left = 12'd100; step();
        chk_burst("R10 one-cycle latency", 1, 0, MAXB);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_bypass();
        t_skip();
        t_priority();
        t_packed();
        t_disconnect();
        t_parity();
        t_gating();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule